// File: doc/BRIEF.md
# Flash Erase and Program Command Sequencer

This block sits on the host side of a parallel flash device. It takes one request at a time on a valid/ready handshake: erase the block that holds an address, program one byte, set a block's lock, or clear the lock bits. For each request it writes the two-cycle command pair onto a synchronous flash bus. The bus has an address, write data, a write strobe and a read strobe, and read data returns one cycle after the read strobe. The block then reads the status byte until the device reports ready and turns the error bits into a 3-bit result code. Every request ends by putting the device back into array-read mode before `done` is raised.

A pause input lets the host pull one array byte out of the device while a long erase or program is in progress. The sequencer writes the suspend command and waits for the status byte to show ready. If the suspended flag for the running operation is set, it switches to array mode, reads the byte at the pause address, returns it on `rd_data` and resumes the operation. If that flag is clear, the operation has already finished and is judged at once. A poll budget set by a parameter stops a device that never becomes ready.

Top module: `nvm_cmd_sequencer`

## Requirements
- R1: An erase request writes 20h and then D0h, both at the request address, and reports result 0 when the final status has no error bits.
- R2: A program request writes 40h and then the data byte at the request address, so the byte is stored in the device, and reports result 0.
- R3: A lock-set request (req_op=2) writes 60h then 01h; a lock-clear request (req_op=3) writes 60h then D0h.
- R4: The status byte is read repeatedly and judged only after a read shows bit 7 = 1; any number of busy reads below the poll budget still gives the correct result.
- R5: Errors are ranked in this order: status bit 3 gives result 1, otherwise bit 1 gives result 2, otherwise bits 4 and 5 both set give result 3.
- R6: If none of the ranked errors is present, the operation's own failure bit gives result 4. That bit is bit 5 for erase and lock-clear, and bit 4 for program and lock-set.
- R7: A request that ends in error writes 50h and then FFh; a successful request writes only FFh. In both cases FFh is the last write before `done`.
- R8: If MAX_POLLS status reads in a row show bit 7 = 0, the request ends with result 5, after a 50h and an FFh write.
- R9: If pause_req is high during a busy erase or program, the block writes B0h. If the final suspend status shows bit 6 (erase) or bit 2 (program) set, it writes FFh, reads pause_addr, raises rd_valid with that byte for one cycle, writes D0h and then continues polling. This happens at most once per request.
- R10: If the suspend status shows ready with that suspended bit clear, no read and no D0h resume follow, and the request is judged from that status.
- R11: req_ready is high only while idle, a request is taken on req_valid and req_ready both high, and done is a one-cycle pulse with result valid alongside it; after reset the block is idle with no strobe active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 erase, 1 program, 2 lock set, 3 lock clear |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| pause_req | input | 1 | Suspend the running operation for one read |
| pause_addr | input | AW | Address read while suspended |
| rd_valid | output | 1 | Suspended read data valid |
| rd_data | output | 8 | Byte read while suspended |
| done | output | 1 | Request finished (one-cycle pulse) |
| result | output | 3 | 0 ok, 1 voltage, 2 protect, 3 sequence, 4 failed, 5 timeout |
| f_addr | output | AW | Flash bus address |
| f_wdata | output | 8 | Flash bus write data |
| f_we | output | 1 | Flash bus write strobe |
| f_re | output | 1 | Flash bus read strobe |
| f_rdata | input | 8 | Flash read data, valid the cycle after f_re |

## Verification
Each status read takes two cycles: the strobe goes out in one cycle and the byte is judged in the next. `done` therefore comes after the two command writes, two cycles for each status read, an optional 50h write and the closing FFh write. A model that tracks that time would be fragile, so the bench ties each result to its event and not to a cycle count. A monitor samples on falling edges, pops the expected result code from a queue when `done` is high, and compares the suspended-read byte whenever `rd_valid` is high. After each `done`, the bench reads the command log and the mode recorded by the behavioural device model to check the write order.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;
    typedef enum logic [1:0] {OP_ERASE = 2'd0, OP_WRITE = 2'd1, OP_LOCK = 2'd2, OP_UNLOCK = 2'd3} op_e;
    typedef enum logic [2:0] {RC_OK = 3'd0, RC_VOLT = 3'd1, RC_PROT = 3'd2, RC_SEQ = 3'd3,
                              RC_FAIL = 3'd4, RC_TIMEOUT = 3'd5} rc_e;
    typedef enum logic [3:0] {S_IDLE, S_CMD1, S_CMD2, S_POLL, S_POLLW, S_SUS, S_SPOLL, S_SPOLLW,
                              S_SARR, S_SRD, S_SRDW, S_RES, S_CLR, S_ARR, S_DONE} seq_state_e;

    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_LOCKSET = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SETBIT  = 8'h01;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;
    localparam logic [7:0] CMD_ARRAY   = 8'hFF;

    function automatic logic [7:0] setup_cmd(op_e op);
        case (op)
            OP_ERASE: return CMD_ERASE;
            OP_WRITE: return CMD_PROG;
            default:  return CMD_LOCKSET;
        endcase
    endfunction
endpackage

// File: rtl/nvm_status_judge.sv
module nvm_status_judge
    import nvm_seq_pkg::*;
(
    input  op_e        op,
    input  logic [7:0] status,
    output rc_e        code,
    output logic       sus_hit
);
    logic own_bit;

    always_comb begin
        own_bit = (op == OP_ERASE || op == OP_UNLOCK) ? status[5] : status[4];
        if (status[3])                   code = RC_VOLT;
        else if (status[1])              code = RC_PROT;
        else if (status[4] && status[5]) code = RC_SEQ;
        else if (own_bit)                code = RC_FAIL;
        else                             code = RC_OK;
        case (op)
            OP_ERASE: sus_hit = status[6];
            OP_WRITE: sus_hit = status[2];
            default:  sus_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvm_poll_timer.sv
module nvm_poll_timer #(
    parameter int MAX_POLLS = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q >= LIMIT);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
endmodule

// File: rtl/nvm_cmd_sequencer.sv
module nvm_cmd_sequencer
    import nvm_seq_pkg::*;
#(
    parameter int AW        = 20,
    parameter int MAX_POLLS = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          pause_req,
    input  logic [AW-1:0] pause_addr,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          done,
    output logic [2:0]    result,
    output logic [AW-1:0] f_addr,
    output logic [7:0]    f_wdata,
    output logic          f_we,
    output logic          f_re,
    input  logic [7:0]    f_rdata
);
    typedef struct packed {
        seq_state_e    st;
        op_e           op;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [AW-1:0] paddr;
        logic          paused;
        rc_e           code;
    } seq_t;

    seq_t r_d, r_q;
    rc_e  judged;
    logic sus_hit, tmr_last, tmr_clear, tmr_tick;

    nvm_status_judge u_judge (
        .op(r_q.op), .status(f_rdata), .code(judged), .sus_hit(sus_hit)
    );

    nvm_poll_timer #(.MAX_POLLS(MAX_POLLS)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .tick(tmr_tick), .last(tmr_last)
    );

    always_comb begin
        r_d       = r_q;
        tmr_clear = 1'b0;
        tmr_tick  = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                tmr_clear = 1'b1;
                if (req_valid) begin
                    r_d.st     = S_CMD1;
                    r_d.op     = op_e'(req_op);
                    r_d.addr   = req_addr;
                    r_d.data   = req_data;
                    r_d.paused = 1'b0;
                    r_d.code   = RC_OK;
                end
            end
            S_CMD1:  r_d.st = S_CMD2;
            S_CMD2:  r_d.st = S_POLL;
            S_POLL:  r_d.st = S_POLLW;
            S_POLLW: begin
                if (f_rdata[7]) begin
                    r_d.code = judged;
                    r_d.st   = (judged == RC_OK) ? S_ARR : S_CLR;
                end else if (pause_req && !r_q.paused &&
                             (r_q.op == OP_ERASE || r_q.op == OP_WRITE)) begin
                    r_d.st     = S_SUS;
                    r_d.paused = 1'b1;
                    r_d.paddr  = pause_addr;
                end else if (tmr_last) begin
                    r_d.code = RC_TIMEOUT;
                    r_d.st   = S_CLR;
                end else begin
                    tmr_tick = 1'b1;
                    r_d.st   = S_POLL;
                end
            end
            S_SUS:   r_d.st = S_SPOLL;
            S_SPOLL: r_d.st = S_SPOLLW;
            S_SPOLLW: begin
                if (f_rdata[7]) begin
                    if (sus_hit) begin
                        r_d.st = S_SARR;
                    end else begin
                        r_d.code = judged;
                        r_d.st   = (judged == RC_OK) ? S_ARR : S_CLR;
                    end
                end else if (tmr_last) begin
                    r_d.code = RC_TIMEOUT;
                    r_d.st   = S_CLR;
                end else begin
                    tmr_tick = 1'b1;
                    r_d.st   = S_SPOLL;
                end
            end
            S_SARR:  r_d.st = S_SRD;
            S_SRD:   r_d.st = S_SRDW;
            S_SRDW:  r_d.st = S_RES;
            S_RES:   r_d.st = S_POLL;
            S_CLR:   r_d.st = S_ARR;
            S_ARR:   r_d.st = S_DONE;
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        f_we    = 1'b0;
        f_re    = 1'b0;
        f_addr  = r_q.addr;
        f_wdata = 8'h00;
        case (r_q.st)
            S_CMD1: begin f_we = 1'b1; f_wdata = setup_cmd(r_q.op); end
            S_CMD2: begin
                f_we = 1'b1;
                case (r_q.op)
                    OP_WRITE: f_wdata = r_q.data;
                    OP_LOCK:  f_wdata = CMD_SETBIT;
                    default:  f_wdata = CMD_CONFIRM;
                endcase
            end
            S_POLL, S_SPOLL: f_re = 1'b1;
            S_SUS:  begin f_we = 1'b1; f_wdata = CMD_SUSPEND; end
            S_SARR, S_ARR: begin f_we = 1'b1; f_wdata = CMD_ARRAY; end
            S_SRD:  begin f_re = 1'b1; f_addr = r_q.paddr; end
            S_RES:  begin f_we = 1'b1; f_wdata = CMD_CONFIRM; end
            S_CLR:  begin f_we = 1'b1; f_wdata = CMD_CLRSTAT; end
            default: ;
        endcase
    end

    assign req_ready = (r_q.st == S_IDLE);
    assign done      = (r_q.st == S_DONE);
    assign result    = r_q.code;
    assign rd_valid  = (r_q.st == S_SRDW);
    assign rd_data   = f_rdata;

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_we && f_re));
    assert_array_before_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (f_we && f_wdata == CMD_ARRAY && !rd_valid && $past(f_we && f_wdata == CMD_CLRSTAT)) |=> done);
    assert_result_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd5));
    assert_resume_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (f_we && f_wdata == CMD_CONFIRM));
endmodule

// File: tb/sim_nvm_cmd_sequencer.sv
module sim_nvm_cmd_sequencer;
    localparam int AW = 12;
    localparam int MP = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, pause_req = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0, pause_addr = '0;
    logic [7:0] req_data = 8'h00;
    logic req_ready, rd_valid, done, f_we, f_re;
    logic [7:0] rd_data, f_wdata;
    logic [7:0] f_rdata = 8'h00;
    logic [2:0] result;
    logic [AW-1:0] f_addr;

    always #5 clk = ~clk;

    nvm_cmd_sequencer #(.AW(AW), .MAX_POLLS(MP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .pause_req(pause_req), .pause_addr(pause_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .done(done), .result(result), .f_addr(f_addr),
        .f_wdata(f_wdata), .f_we(f_we), .f_re(f_re), .f_rdata(f_rdata)
    );

    // behavioural device model
    int         cfg_busy = 0;
    logic [7:0] cfg_err = 8'h00;
    logic       cfg_sus_done = 1'b0;
    logic       m_arr, m_sus;
    logic [7:0] m_pend, m_errs;
    int         m_kind, m_left, nw, n50, nb0;
    logic [7:0] log_w [0:31];
    logic [AW-1:0] log_a [0:31];
    logic [AW-1:0] m_opa;
    logic [7:0] m_opd;
    logic [7:0] mem [0:255];

    task automatic m_finish();
        m_left = 0;
        m_errs = cfg_err;
        if (cfg_err == 8'h00) begin
            if (m_kind == 2) mem[m_opa[7:0]] = m_opd;
            if (m_kind == 1) mem[m_opa[7:0]] = 8'hFF;
        end
    endtask

    function automatic logic [7:0] m_status();
        logic rdy;
        rdy = (m_left == 0) || m_sus;
        return {rdy, m_sus && m_kind == 1, m_errs[5:3], m_sus && m_kind == 2, m_errs[1], 1'b0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arr = 1'b1; m_sus = 1'b0; m_pend = 8'h00; m_errs = 8'h00;
            m_kind = 0; m_left = 0; nw = 0; n50 = 0; nb0 = 0;
        end else begin
            if (f_re) begin
                f_rdata <= m_arr ? mem[f_addr[7:0]] : m_status();
                if (!m_arr && m_left > 0 && !m_sus) begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_finish();
                end
            end
            if (f_we) begin
                if (nw < 32) begin log_w[nw] = f_wdata; log_a[nw] = f_addr; end
                nw = nw + 1;
                if (m_pend != 8'h00) begin
                    m_kind = (m_pend == 8'h20) ? 1 : (m_pend == 8'h40) ? 2 : 3;
                    m_opa = f_addr; m_opd = f_wdata; m_pend = 8'h00; m_arr = 1'b0;
                    m_left = cfg_busy;
                    if (cfg_busy == 0) m_finish();
                end else begin
                    case (f_wdata)
                        8'h20, 8'h40, 8'h60: begin m_pend = f_wdata; m_arr = 1'b0; end
                        8'h50: begin m_errs = 8'h00; n50 = n50 + 1; end
                        8'hFF: m_arr = 1'b1;
                        8'hB0: begin
                            nb0 = nb0 + 1; m_arr = 1'b0;
                            if (m_left > 0 && !m_sus) begin
                                if (cfg_sus_done) m_finish();
                                else m_sus = 1'b1;
                            end
                        end
                        8'hD0: begin m_arr = 1'b0; m_sus = 1'b0; end
                        default: ;
                    endcase
                end
            end
        end
    end

    // scoreboard
    int checks = 0, fails = 0, nrd = 0;
    int exp_q [$];
    logic [7:0] exp_rd [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) check(1'b0, "R11 unexpected done", 1, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                check(result == 3'(e), "R5/R6/R8 result code", int'(result), e);
            end
        end
        if (rst_n && rd_valid) begin
            nrd++;
            if (exp_rd.size() == 0) check(1'b0, "R10 unexpected suspended read", int'(rd_data), 0);
            else begin
                logic [7:0] e8;
                e8 = exp_rd.pop_front();
                check(rd_data == e8, "R9 suspended read data", int'(rd_data), int'(e8));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_op(input int op, input int a, input int d, input int exp_rc);
        exp_q.push_back(exp_rc);
        req_op = 2'(op); req_addr = AW'(a); req_data = 8'(d); req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic end_checks(input string tag, input int want50);
        check(m_arr == 1'b1 && log_w[nw-1] == 8'hFF, {tag, " R7 array mode restored"}, int'(log_w[nw-1]), 8'hFF);
        check(n50 == want50, {tag, " R7 status clear count"}, n50, want50);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 100000) begin @(posedge clk); wd++; end
        check(1'b0, "watchdog expired", wd, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        do_reset();
        // R11 reset state
        check(req_ready && !done && !f_we && !f_re && !rd_valid, "R11 reset idle", int'(req_ready), 1);

        // R1 erase, R4 busy polls
        cfg_busy = 3; cfg_err = 8'h00;
        do_op(0, 12'h345, 0, 0);
        check(log_w[0] == 8'h20 && log_w[1] == 8'hD0, "R1 erase command pair",
              int'({log_w[0], log_w[1]}), 16'h20D0);
        check(log_a[1] == 12'h345, "R1 confirm address", int'(log_a[1]), 12'h345);
        end_checks("erase", 0);

        // R2 program
        do_reset(); cfg_busy = 2;
        do_op(1, 12'h035, 8'hA7, 0);
        check(log_w[0] == 8'h40 && log_w[1] == 8'hA7 && log_a[1] == 12'h035, "R2 program sequence",
              int'({log_w[0], log_w[1]}), 16'h40A7);
        check(mem[8'h35] == 8'hA7, "R2 byte stored", int'(mem[8'h35]), 8'hA7);

        // R3 lock set and clear
        do_reset(); cfg_busy = 1;
        do_op(2, 12'h100, 0, 0);
        check(log_w[0] == 8'h60 && log_w[1] == 8'h01, "R3 lock set pair", int'({log_w[0], log_w[1]}), 16'h6001);
        do_reset();
        do_op(3, 12'h000, 0, 0);
        check(log_w[0] == 8'h60 && log_w[1] == 8'hD0, "R3 lock clear pair", int'({log_w[0], log_w[1]}), 16'h60D0);

        // R4 long busy just under the budget
        do_reset(); cfg_busy = MP - 1;
        do_op(0, 12'h010, 0, 0);

        // R5 priority, R6 own bit, R7 clear on error
        do_reset(); cfg_busy = 2; cfg_err = 8'h3A;
        do_op(0, 12'h020, 0, 1);
        end_checks("voltage R5", 1);
        do_reset(); cfg_err = 8'h32;
        do_op(0, 12'h020, 0, 2);
        do_reset(); cfg_err = 8'h30;
        do_op(1, 12'h020, 8'h11, 3);
        do_reset(); cfg_err = 8'h20;
        do_op(0, 12'h020, 0, 4);
        do_reset(); cfg_err = 8'h10;
        do_op(1, 12'h020, 8'h11, 4);
        end_checks("write fail R6", 1);
        do_reset(); cfg_err = 8'h10;
        do_op(2, 12'h020, 0, 4);

        // R8 timeout
        do_reset(); cfg_err = 8'h00; cfg_busy = 1000;
        do_op(0, 12'h030, 0, 5);
        end_checks("timeout R8", 1);

        // R9 suspend, read, resume
        do_reset(); cfg_busy = 1;
        do_op(1, 12'h010, 8'h5C, 0);
        cfg_busy = 10; pause_addr = 12'h010; pause_req = 1'b1; nrd = 0;
        exp_rd.push_back(8'h5C);
        do_op(0, 12'h080, 0, 0);
        pause_req = 1'b0;
        check(nrd == 1, "R9 one suspended read", nrd, 1);
        check(nb0 == 1, "R9 one suspend command", nb0, 1);
        end_checks("suspend R9", 0);

        // R10 suspend finds operation complete
        do_reset(); cfg_busy = 10; cfg_sus_done = 1'b1; pause_addr = 12'h000; pause_req = 1'b1; nrd = 0;
        do_op(1, 12'h044, 8'h9E, 0);
        pause_req = 1'b0; cfg_sus_done = 1'b0;
        check(nrd == 0 && nb0 == 1, "R10 no read after completed suspend", nrd, 0);
        check(log_w[nw-2] == 8'hB0, "R10 no resume written", int'(log_w[nw-2]), 8'hB0);
        check(mem[8'h44] == 8'h9E, "R10 program completed", int'(mem[8'h44]), 8'h9E);

        check(exp_q.size() == 0, "R11 every request reported done", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule